// File: doc/BRIEF.md
# Serial ADC Power-Mode Sequencer

This block is the host-side master for a dual-channel serial converter. The converter has one chip select and one serial clock, and it returns two data lines. The block drives chip select and the serial clock itself. On a conversion command it runs a 16-clock frame and captures a 14-bit result from each data line.

Three other commands control the converter's power state, which the converter decodes only from where chip select rises within a frame. A partial power-down command runs a frame that is cut short after the fifth falling clock edge. A full power-down command runs two such short frames back to back. A wake command runs a complete dummy frame. The data from that dummy frame is flagged as invalid and is never presented as a result.

After a wake frame, the block holds busy high for a programmable power-up time before it accepts further work. The partial and full power-down states each have their own delay input. The block reports the converter's power state at all times and rejects commands that do not suit that state.

Top module: `adcPowerSeq`

## Requirements
- R1: While reset is asserted, csN=1, sclk=1, busy=0, powerState=0 (active), resultValid=0, cmdError=0, dataInvalid=0, and both results are 0.
- R2: A command accepted in idle pulls csN low on the accepting edge. sclk then toggles on every system clock, starting from high. A conversion or wake frame holds csN low for 32 system clocks and gives exactly 16 falling sclk edges. While csN is high, sclk stays high.
- R3: In a conversion frame (cmdOp=0), each data line is sampled on the system edge where sclk falls, 16 times. The first two bits are discarded and the next 14 form the result, MSB first. resultA comes from sdataA and resultB from sdataB. resultValid pulses for one cycle on the edge where csN rises, and the results hold until the next conversion.
- R4: A partial power-down command (cmdOp=1) raises csN on the system edge after the 5th falling sclk edge and gives no further sclk edges. powerState becomes 1 on that edge.
- R5: A full power-down command (cmdOp=2) runs two interrupted frames of the R4 shape. csN stays high for one system clock between them. powerState becomes 2 when the second frame ends.
- R6: A wake command (cmdOp=3) runs a full 16-clock frame. At its end, dataInvalid pulses for one cycle, resultValid stays low and the results keep their earlier values.
- R7: When a wake frame ends, powerState becomes 0. busy then stays high for D+1 further cycles, where D is partialDelay if the converter was in partial power-down and fullDelay if it was in full power-down. D is sampled on the frame's last edge. Once busy is low, a waiting command is accepted on the next edge.
- R8: In idle, a conversion or power-down command while powerState is not 0, or a wake command while powerState is 0, is rejected. The block then pulses cmdError for one cycle, starts no frame and leaves powerState unchanged.
- R9: cmdValid while busy is high has no effect: no error, no frame and no state change.
- R10: Values on sdataA and sdataB while csN is high do not affect any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request, sampled when idle |
| cmdOp | input | 2 | 0 convert, 1 partial down, 2 full down, 3 wake |
| partialDelay | input | 16 | Power-up wait after leaving partial power-down, in cycles |
| fullDelay | input | 16 | Power-up wait after leaving full power-down, in cycles |
| csN | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, system clock divided by two, idles high |
| sdataA | input | 1 | Serial data from channel A |
| sdataB | input | 1 | Serial data from channel B |
| resultValid | output | 1 | One-cycle pulse when a new result pair is presented |
| resultA | output | 14 | Last valid channel A result |
| resultB | output | 14 | Last valid channel B result |
| dataInvalid | output | 1 | One-cycle pulse at the end of a wake frame |
| cmdError | output | 1 | One-cycle pulse on a rejected command |
| busy | output | 1 | A frame or the power-up wait is in progress |
| powerState | output | 2 | 0 active, 1 partial down, 2 full down |

## Verification
Two pairs of events can fall on the same cycle. The first pair is the end of the power-up wait and a pending command. The bench raises a conversion request while the wake frame is still running and holds it through the wait. The request must be ignored until busy drops, then accepted on the very next edge. The second pair is chip select changing level and activity on the data lines. The bench drives random bits on both lines whenever chip select is high, including the cycles right next to each frame boundary. A behavioural model compares every output on every clock, so any captured stray bit shows up as a wrong result.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_PART = 2'd1,
    OP_FULL = 2'd2,
    OP_WAKE = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_PARTIAL = 2'd1,
    PWR_FULL    = 2'd2
  } pwr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadResult;
  } dpStrobe_t;

endpackage

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int LANES      = 2,
  parameter int DATA_W     = 14,
  parameter int FRAME_CLKS = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LANES-1:0]              sdata,
  input  dpStrobe_t                     strobe,
  output logic [LANES-1:0][DATA_W-1:0]  result,
  output logic                          resultValid
);

  localparam int SHIFT_W = FRAME_CLKS;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [SHIFT_W-1:0] shiftReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg  <= '0;
        result[g] <= '0;
      end else begin
        if (strobe.shiftEn) begin
          shiftReg <= {shiftReg[SHIFT_W-2:0], sdata[g]};
        end
        if (strobe.loadResult) begin
          // leading bits fall off the top; the low DATA_W bits are the sample
          result[g] <= shiftReg[DATA_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.loadResult;
    end
  end

endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int FRAME_CLKS = 16,
  parameter int EARLY_FALL = 5,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [CNT_W-1:0] partialDelay,
  input  logic [CNT_W-1:0] fullDelay,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic [1:0]       powerState,
  output logic             cmdError,
  output logic             dataInvalid,
  output dpStrobe_t        strobe
);

  localparam int FULL_EDGES  = 2 * FRAME_CLKS;
  localparam int EARLY_EDGES = 2 * EARLY_FALL;
  localparam int EDGE_W      = $clog2(FULL_EDGES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP, S_WAIT} seqState_e;

  seqState_e        state;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] nextEdge;
  logic [EDGE_W-1:0] frameLimit;
  cmdOp_e           curOp;
  logic             secondPass;
  pwr_e             pwr;
  logic [CNT_W-1:0] waitCnt;
  logic             isDown;
  logic             frameEnd;
  logic             legal;

  always_comb begin
    nextEdge   = edgeCnt + 1'b1;
    isDown     = (curOp == OP_PART) || (curOp == OP_FULL);
    frameLimit = isDown ? EDGE_W'(EARLY_EDGES) : EDGE_W'(FULL_EDGES);
    frameEnd   = (state == S_FRAME) && (nextEdge == frameLimit);
    legal      = (cmdOp == OP_WAKE) ? (pwr != PWR_ACTIVE) : (pwr == PWR_ACTIVE);
    strobe.shiftEn    = (state == S_FRAME) && !edgeCnt[0];
    strobe.loadResult = frameEnd && (curOp == OP_CONV);
  end

  assign busy       = (state != S_IDLE);
  assign powerState = pwr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      edgeCnt     <= '0;
      curOp       <= OP_CONV;
      secondPass  <= 1'b0;
      pwr         <= PWR_ACTIVE;
      waitCnt     <= '0;
      csN         <= 1'b1;
      sclk        <= 1'b1;
      cmdError    <= 1'b0;
      dataInvalid <= 1'b0;
    end else begin
      cmdError    <= 1'b0;
      dataInvalid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmdValid) begin
            if (legal) begin
              state      <= S_FRAME;
              curOp      <= cmdOp_e'(cmdOp);
              edgeCnt    <= '0;
              secondPass <= 1'b0;
              csN        <= 1'b0;
              sclk       <= 1'b1;
            end else begin
              cmdError <= 1'b1;
            end
          end
        end
        S_FRAME: begin
          edgeCnt <= nextEdge;
          sclk    <= ~sclk;
          if (frameEnd) begin
            csN  <= 1'b1;
            sclk <= 1'b1;
            unique case (curOp)
              OP_CONV: state <= S_IDLE;
              OP_PART: begin
                pwr   <= PWR_PARTIAL;
                state <= S_IDLE;
              end
              OP_FULL: begin
                if (!secondPass) begin
                  secondPass <= 1'b1;
                  state      <= S_GAP;
                end else begin
                  pwr   <= PWR_FULL;
                  state <= S_IDLE;
                end
              end
              OP_WAKE: begin
                dataInvalid <= 1'b1;
                waitCnt     <= (pwr == PWR_PARTIAL) ? partialDelay : fullDelay;
                pwr         <= PWR_ACTIVE;
                state       <= S_WAIT;
              end
            endcase
          end
        end
        S_GAP: begin
          csN     <= 1'b0;
          sclk    <= 1'b1;
          edgeCnt <= '0;
          state   <= S_FRAME;
        end
        S_WAIT: begin
          if (waitCnt == '0) begin
            state <= S_IDLE;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adcPowerSeq.sv
module adcPowerSeq
  import adcSeqPkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int FRAME_CLKS = 16,
  parameter int EARLY_FALL = 5,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [CNT_W-1:0]  partialDelay,
  input  logic [CNT_W-1:0]  fullDelay,
  output logic              csN,
  output logic              sclk,
  input  logic              sdataA,
  input  logic              sdataB,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultA,
  output logic [DATA_W-1:0] resultB,
  output logic              dataInvalid,
  output logic              cmdError,
  output logic              busy,
  output logic [1:0]        powerState
);

  localparam int LANES = 2;

  dpStrobe_t                        strobe;
  logic [LANES-1:0][DATA_W-1:0]     laneResult;

  adcSeqCtrl #(
    .FRAME_CLKS (FRAME_CLKS),
    .EARLY_FALL (EARLY_FALL),
    .CNT_W      (CNT_W)
  ) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .partialDelay (partialDelay),
    .fullDelay    (fullDelay),
    .csN          (csN),
    .sclk         (sclk),
    .busy         (busy),
    .powerState   (powerState),
    .cmdError     (cmdError),
    .dataInvalid  (dataInvalid),
    .strobe       (strobe)
  );

  adcSeqDatapath #(
    .LANES      (LANES),
    .DATA_W     (DATA_W),
    .FRAME_CLKS (FRAME_CLKS)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .sdata       ({sdataB, sdataA}),
    .strobe      (strobe),
    .result      (laneResult),
    .resultValid (resultValid)
  );

  assign resultA = laneResult[0];
  assign resultB = laneResult[1];

endmodule

// File: rtl/adcPowerSeqChecker.sv
module adcPowerSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       busy,
  input logic [1:0] powerState,
  input logic       resultValid,
  input logic       cmdError,
  input logic       dataInvalid
);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_valid_at_cs_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(csN));

  p_state_move_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(powerState) |-> $rose(csN));

  p_invalid_then_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataInvalid |-> (busy && !resultValid && powerState == 2'd0));

  p_state_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    powerState != 2'd3);

  p_error_while_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> (!busy && csN));

endmodule

bind adcPowerSeq adcPowerSeqChecker chk (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (csN),
  .sclk        (sclk),
  .busy        (busy),
  .powerState  (powerState),
  .resultValid (resultValid),
  .cmdError    (cmdError),
  .dataInvalid (dataInvalid)
);

// File: tb/adcPowerSeq_test.sv
module adcPowerSeq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [15:0] partialDelay = 16'd5;
  logic [15:0] fullDelay = 16'd9;
  logic        csN, sclk, resultValid, dataInvalid, cmdError, busy;
  logic        sdataA = 1'b0, sdataB = 1'b0;
  logic [13:0] resultA, resultB;
  logic [1:0]  powerState;

  adcPowerSeq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .partialDelay(partialDelay), .fullDelay(fullDelay),
    .csN(csN), .sclk(sclk), .sdataA(sdataA), .sdataB(sdataB),
    .resultValid(resultValid), .resultA(resultA), .resultB(resultB),
    .dataInvalid(dataInvalid), .cmdError(cmdError), .busy(busy),
    .powerState(powerState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference model state
  int mMode = 0;   // 0 idle, 1 frame, 2 gap, 3 wait
  int e = 0;
  int mOp = 0;
  bit mPass = 0;
  int pst = 0;
  int waitCnt = 0;
  int lim = 0;
  bit okCmd = 0;
  bit xCsN = 1, xSclk = 1, xBusy = 0, xValid = 0, xErr = 0, xInv = 0;
  logic [13:0] xResA = '0, xResB = '0;
  logic [15:0] wA = '0, wB = '0;
  int falls = 0;
  bit prevSclk = 1, prevCsN = 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mMode = 0; pst = 0; xCsN = 1; xSclk = 1; xBusy = 0;
      xValid = 0; xErr = 0; xInv = 0; xResA = '0; xResB = '0;
    end else begin
      xValid = 0; xErr = 0; xInv = 0;
      case (mMode)
        0: if (cmdValid) begin
          okCmd = (cmdOp == 2'd3) ? (pst != 0) : (pst == 0);
          if (okCmd) begin
            mMode = 1; e = 0; mOp = int'(cmdOp); mPass = 0; xCsN = 0; xSclk = 1;
          end else begin
            xErr = 1;
          end
        end
        1: begin
          e++;
          xSclk = (e % 2 == 0);
          lim = (mOp == 1 || mOp == 2) ? 10 : 32;
          if (e == lim) begin
            xCsN = 1; xSclk = 1;
            case (mOp)
              0: begin xValid = 1; xResA = wA[13:0]; xResB = wB[13:0]; mMode = 0; end
              1: begin pst = 1; mMode = 0; end
              2: if (!mPass) begin mPass = 1; mMode = 2; end
                 else begin pst = 2; mMode = 0; end
              default: begin
                xInv = 1;
                waitCnt = (pst == 1) ? int'(partialDelay) : int'(fullDelay);
                pst = 0; mMode = 3;
              end
            endcase
          end
        end
        2: begin mMode = 1; e = 0; xCsN = 0; xSclk = 1; end
        default: if (waitCnt == 0) mMode = 0; else waitCnt--;
      endcase
      xBusy = (mMode != 0);
    end
  end

  // compare every cycle, then drive the data lines for the next edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 R4 R5 csN", int'(csN), int'(xCsN));
      chk("R2 R4 sclk", int'(sclk), int'(xSclk));
      chk("R7 R9 busy", int'(busy), int'(xBusy));
      chk("R4 R5 R7 R8 powerState", int'(powerState), pst);
      chk("R3 R6 resultValid", int'(resultValid), int'(xValid));
      chk("R3 R6 R10 resultA", int'(resultA), int'(xResA));
      chk("R3 R6 R10 resultB", int'(resultB), int'(xResB));
      chk("R8 R9 cmdError", int'(cmdError), int'(xErr));
      chk("R6 dataInvalid", int'(dataInvalid), int'(xInv));
      if (prevSclk && !sclk && !csN) falls++;
      if (csN && !prevCsN) begin
        if (mOp == 1 || mOp == 2) chk("R4 falls in short frame", falls, 5);
        else chk("R2 falls in full frame", falls, 16);
        falls = 0;
      end
      prevSclk = sclk;
      prevCsN = csN;
    end
    if (mMode == 1) begin
      sdataA = wA[15 - e/2];
      sdataB = wB[15 - e/2];
    end else begin
      sdataA = 1'($urandom);
      sdataB = 1'($urandom);
    end
  end

  task automatic waitIdle();
    while (mMode != 0) @(negedge clk);
  endtask

  task automatic doCmd(input int op, input logic [13:0] a, input logic [13:0] b);
    wA = {2'($urandom), a};
    wB = {2'($urandom), b};
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op);
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 csN", int'(csN), 1);
    chk("R1 sclk", int'(sclk), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 powerState", int'(powerState), 0);
    chk("R1 resultValid", int'(resultValid), 0);
    chk("R1 results", int'({resultA, resultB}), 0);
    chk("R1 pulses", int'({cmdError, dataInvalid}), 0);
    rstN = 1'b1;

    doCmd(0, 14'h1234, 14'h2abc);            // R3
    doCmd(0, 14'h3fff, 14'h0000);            // R3
    // R9: a request during a frame is ignored
    wA = {2'b11, 14'h0155}; wB = {2'b10, 14'h2aaa};
    @(negedge clk); cmdValid = 1'b1; cmdOp = 2'd0;
    @(negedge clk); cmdValid = 1'b0;
    repeat (6) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk); cmdValid = 1'b0;
    waitIdle(); @(negedge clk);
    doCmd(3, 14'h0, 14'h0);                  // R8 wake while active
    doCmd(1, 14'h0, 14'h0);                  // R4 partial down
    doCmd(0, 14'h0, 14'h0);                  // R8 convert while down
    doCmd(2, 14'h0, 14'h0);                  // R8 full while partial
    // R6 R7: wake, then a request held through the wait
    partialDelay = 16'd5;
    wA = 16'hffff; wB = 16'hffff;
    @(negedge clk); cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk); cmdOp = 2'd0;
    wA = {2'b01, 14'h2468}; wB = {2'b00, 14'h1357};
    while (mMode != 1 || e != 0 || cmdOp != 2'd0 || busy !== 1'b0 && mMode != 1) @(negedge clk);
    while (mMode != 3) @(negedge clk);
    while (mMode != 1) @(negedge clk);
    cmdValid = 1'b0;
    waitIdle(); @(negedge clk);
    doCmd(2, 14'h0, 14'h0);                  // R5 full down
    doCmd(1, 14'h0, 14'h0);                  // R8 partial while full
    fullDelay = 16'd9;
    doCmd(3, 14'h0, 14'h0);                  // R7 full delay
    doCmd(0, 14'h0abc, 14'h3001);            // R3
    partialDelay = 16'd0;
    doCmd(1, 14'h0, 14'h0);
    doCmd(3, 14'h0, 14'h0);                  // R7 zero delay
    doCmd(0, 14'h2001, 14'h1ffe);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected below %0d", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule